// File: doc/BRIEF.md
# Granularity-aware channel address dehasher

This block undoes channel hashing on a 48-bit physical address when memory is spread over a power-of-two number of channels. Five address bits (8, 9, 12, 13 and 14) can carry a channel-select hash. The channel count and the interleave granularity (1 KiB or 2 KiB) decide which of these bits are hashed for a given mapping. Each active bit is corrected by XOR-ing it with up to four higher address bits. Separate enable flags for the 64K, 2M, 1G and 1T regions gate those four terms.

The set of active bits comes from a small mask. The mask starts as a run of ones at bit 8, one bit for each channel-select bit. A gap is then opened in that run: two zeros at bit 10 for 1 KiB granularity, or three zeros at bit 9 for 2 KiB granularity. The corrected address is registered, and a one-cycle valid pulse goes with it. A channel count that is not 2, 4, 8 or 16 is rejected: the address passes through unchanged and an error flag is raised with it.

Top module: `addr_dehash`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low in every other cycle.
- R2: With `gran_1k`=1, the active target bits are {8} for 2 channels, {8,9} for 4, {8,9,12} for 8 and {8,9,12,13} for 16.
- R3: With `gran_1k`=0, the active target bits are {8} for 2 channels, {8,12} for 4, {8,12,13} for 8 and {8,12,13,14} for 16.
- R4: Number the targets 8, 9, 12, 13, 14 as k=0..4. An active target is inverted when this parity is 1: (`en_64k`&addr[16+k]) ^ (`en_2m`&addr[21+k]) ^ (`en_1g`&addr[30+k]) ^ (`en_1t`&addr[40+k]). The parity is taken over the input address.
- R5: With all four enable flags low, `out_addr` equals the input address.
- R6: Every bit other than 8, 9, 12, 13 and 14 passes to `out_addr` unchanged.
- R7: If `chan_cnt` is not 2, 4, 8 or 16, `out_err` is 1 and `out_addr` equals the input address. Otherwise `out_err` is 0.
- R8: During reset, `out_valid`, `out_err` and `out_addr` are all 0.
- R9: `out_addr` and `out_err` keep their values in cycles when `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input address is present |
| in_addr | input | 48 | Hashed address |
| chan_cnt | input | 5 | Total interleaved channels |
| gran_1k | input | 1 | 1 = 1 KiB granularity, 0 = 2 KiB |
| en_64k | input | 1 | Enable the 64K hash term |
| en_2m | input | 1 | Enable the 2M hash term |
| en_1g | input | 1 | Enable the 1G hash term |
| en_1t | input | 1 | Enable the 1T hash term |
| out_valid | output | 1 | Result pulse |
| out_addr | output | 48 | Dehashed address |
| out_err | output | 1 | Unsupported channel count |

## Verification
Every result (the corrected address, the error flag and the valid pulse) is due exactly one clock edge after the input is presented. The bench drives the inputs at a falling edge and checks at the next falling edge, so the single register stage lies between the two. It then drops `in_valid` for one cycle and checks again: the valid pulse must be gone and the outputs must hold. The sweep covers channel counts 0 to 17, both granularities, all 16 flag combinations and a set of address patterns.

// File: rtl/addr_dehash.sv
module addr_dehash #(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic [4:0]    chan_cnt,
  input  logic          gran_1k,
  input  logic          en_64k,
  input  logic          en_2m,
  input  logic          en_1g,
  input  logic          en_1t,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          out_err
);
  localparam int NT = 5;

  function automatic int tgt_pos(input int k);
    return (k < 2) ? 8 + k : 10 + k;
  endfunction

  logic [4:0]    cnt_m1;
  logic          cnt_ok;
  logic [15:0]   raw_mask, sel_mask;
  logic [NT-1:0] flip;
  logic [AW-1:0] delta;

  assign cnt_m1   = chan_cnt - 5'd1;
  assign cnt_ok   = (chan_cnt >= 5'd2) && (chan_cnt <= 5'd16) && ((chan_cnt & cnt_m1) == 5'd0);
  assign raw_mask = {4'b0, cnt_m1[3:0], 8'b0};
  assign sel_mask = gran_1k ? {raw_mask[13:10], 2'b00, raw_mask[9:0]}
                            : {raw_mask[12:9], 3'b000, raw_mask[8:0]};

  for (genvar k = 0; k < NT; k++) begin : g_tgt
    localparam int TP = tgt_pos(k);
    assign flip[k] = cnt_ok & sel_mask[TP] &
                     ((en_64k & in_addr[16+k]) ^ (en_2m & in_addr[21+k]) ^
                      (en_1g  & in_addr[30+k]) ^ (en_1t & in_addr[40+k]));
  end

  always_comb begin
    delta = '0;
    for (int k = 0; k < NT; k++) delta[tgt_pos(k)] = flip[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr <= in_addr ^ delta;
        out_err  <= !cnt_ok;
      end
    end
  end
endmodule

module addr_dehash_chk #(
  parameter int AW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [AW-1:0] in_addr,
  input logic [4:0]    chan_cnt,
  input logic          en_64k,
  input logic          en_2m,
  input logic          en_1g,
  input logic          en_1t,
  input logic          out_valid,
  input logic [AW-1:0] out_addr,
  input logic          out_err
);
  localparam logic [AW-1:0] TGT = AW'(48'h7300);

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  // R1
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  // R6
  other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_addr & ~TGT) == ($past(in_addr) & ~TGT)));
  // R7
  err_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_addr == $past(in_addr)));
  // R7
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_err == !(($countones($past(chan_cnt)) == 1) && ($past(chan_cnt) >= 5'd2))));
  // R5
  no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(en_64k | en_2m | en_1g | en_1t)) |-> (out_addr == $past(in_addr)));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_addr) && $stable(out_err)));
endmodule

bind addr_dehash addr_dehash_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_addr_dehash.sv
module test_addr_dehash;
  logic clk = 0, rst_n = 0, in_valid = 0, gran_1k = 0;
  logic en_64k = 0, en_2m = 0, en_1g = 0, en_1t = 0;
  logic [47:0] in_addr = '0;
  logic [4:0] chan_cnt = '0;
  logic out_valid, out_err;
  logic [47:0] out_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  addr_dehash i_addr_dehash (.*);

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] model(input logic [47:0] a, input int cnt, input bit g,
                                        input logic [3:0] f, output bit err);
    int lg;
    bit act;
    logic [47:0] r = a;
    err = !(cnt == 2 || cnt == 4 || cnt == 8 || cnt == 16);
    if (err) return a;
    lg = (cnt == 2) ? 1 : (cnt == 4) ? 2 : (cnt == 8) ? 3 : 4;
    for (int k = 0; k < 5; k++) begin
      int pos = (k < 2) ? 8 + k : 10 + k;
      act = g ? (k < lg) : (k == 0 || (k >= 2 && k <= lg));
      if (act)
        r[pos] ^= (f[0] & a[16+k]) ^ (f[1] & a[21+k]) ^ (f[2] & a[30+k]) ^ (f[3] & a[40+k]);
    end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] exp, prev;
    bit eerr;
    string tag;
    repeat (3) @(negedge clk);
    // R8
    chk(out_valid == 0 && out_err == 0 && out_addr == 0, "R8 reset", {out_valid, out_err, out_addr[45:0]}, 0);
    rst_n = 1;
    @(negedge clk);
    // R1 idle after reset
    chk(out_valid == 0, "R1 idle", 48'(out_valid), 0);
    for (int c = 0; c < 18; c++)
      for (int g = 0; g < 2; g++)
        for (int f = 0; f < 16; f++)
          for (int p = 0; p < 8; p++) begin
            logic [47:0] a;
            case (p)
              0: a = '0;
              1: a = '1;
              2: a = 48'hAAAA_AAAA_AAAA;
              3: a = 48'h5555_5555_5555;
              default: a = 48'(64'(p * 37 + c * 11 + f * 5 + g) * 64'h9E37_79B9_7F4A + 64'h1234_5678);
            endcase
            in_addr = a; chan_cnt = 5'(c); gran_1k = g[0];
            {en_1t, en_1g, en_2m, en_64k} = 4'(f);
            in_valid = 1;
            exp = model(a, c, g[0], 4'(f), eerr);
            @(negedge clk);
            in_valid = 0;
            // R1
            chk(out_valid == 1, "R1 pulse", 48'(out_valid), 1);
            if (eerr) tag = "R7 pass-through";
            else if (f == 0) tag = "R5 no flags";
            else tag = g ? "R2 R4 1K result" : "R3 R4 2K result";
            chk(out_addr == exp, tag, out_addr, exp);
            // R7
            chk(out_err == eerr, "R7 flag", 48'(out_err), 48'(eerr));
            // R6
            chk((out_addr & ~48'h7300) == (a & ~48'h7300), "R6 other bits", out_addr, a);
            prev = out_addr;
            in_addr = ~a; chan_cnt = 5'd3;
            @(negedge clk);
            // R9
            chk(out_valid == 0 && out_addr == prev && out_err == eerr, "R9 hold", out_addr, prev);
          end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule